// File: doc/BRIEF.md
# Bad Block Remapping Table

This block sits in a NAND-style storage controller and translates every logical block number into the physical block that currently holds it. The physical array holds `NUM_LOG` data blocks followed by `NUM_SPARE` reserved spares. After reset the table takes one good/bad marker per physical block from a power-up scan. It then runs a short build pass that points each logical block either at its own physical block or, when that block came bad from the factory, at a spare. Only after this pass does it accept lookups.

At run time, a failed program or erase is reported against the logical block whose operation failed. The table retires the physical block behind that logical block and moves the logical block to the lowest-numbered spare that is good and not yet in use. It also keeps a count of physical blocks that are still usable, and this count only ever falls. When no good spare is left, a failure raises a sticky error and the logical block keeps its old mapping.

Top module: `bbt_remap_table`

## Requirements
- R1: A lookup accepted in one cycle (`lkp_valid` and `lkp_ready` both high) produces `rsp_valid` high for exactly the next cycle, with `rsp_pblk` equal to the mapping in force when the lookup was accepted. `rsp_valid` is never high without such an acceptance.
- R2: While scanning, each cycle with `scan_valid` high delivers the marker for the next physical block, starting at block 0 and going up. `scan_bad`=1 means bad and 0 means good. The scan ends after `NUM_PHYS` markers.
- R3: `lkp_ready` is low from reset until both the scan and the build pass have finished. A lookup presented in that window gives no response.
- R4: In the build pass, a data block (index below `NUM_LOG`) found bad in the scan has its logical block mapped to a spare. A good data block maps to its own index. No lookup ever returns a block that was marked bad at the time of mapping.
- R5: A failure report (`fail_valid` with `fail_lblk`) marks the physical block currently mapped to `fail_lblk` as bad and redirects `fail_lblk` to a newly allocated spare. The change is visible from the cycle after the report.
- R6: Spares are physical blocks `NUM_LOG` to `NUM_PHYS-1`. An allocation takes the lowest-numbered spare that is neither bad nor already in use.
- R7: `usable_count` is `NUM_PHYS` after reset. It drops by one each time a block becomes newly bad, whether from the scan or from a failure report. Reporting a block that is already bad leaves the count unchanged, and the count never rises.
- R8: If a failure needs a spare and none is available, `out_of_spares` goes high and stays high until reset. The failed block is still retired, and the mapping of `fail_lblk` is left as it was.
- R9: In any cycle where `fail_valid` is high, `lkp_ready` is low, so a lookup presented in that cycle is not accepted.
- R10: A failure report made before the table is ready is ignored. It changes neither the mapping nor `usable_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_valid | input | 1 | A scan marker is present |
| scan_bad | input | 1 | Marker value: 1 bad, 0 good |
| lkp_valid | input | 1 | Lookup request |
| lkp_lblk | input | LW | Logical block to translate |
| lkp_ready | output | 1 | Table accepts a lookup this cycle |
| rsp_valid | output | 1 | Lookup result present |
| rsp_pblk | output | PW | Physical block for the accepted lookup |
| fail_valid | input | 1 | Program/erase failure report |
| fail_lblk | input | LW | Logical block whose operation failed |
| usable_count | output | CW | Number of physical blocks not marked bad |
| out_of_spares | output | 1 | Sticky: a failure found no spare |

## Verification
The hardest state to reach is an exhausted spare pool in which one spare was already bad from the factory and another spare has itself failed after being allocated. Only in that state do the skip-over rule, the retirement of a spare and the sticky error all act at once. The stimulus gets there in steps. The scan marks one data block and one spare as bad. Runtime failures then land first on a fresh data block and then on the logical block that is already living on a spare. A last failure finds no spare left. A further failure is then driven together with a lookup in the same cycle, to show that the failure wins and that a block already marked bad is not counted twice.

// File: rtl/bbt_pkg.sv
package bbt_pkg;
    typedef enum logic [1:0] {
        PH_SCAN  = 2'd0,
        PH_BUILD = 2'd1,
        PH_RUN   = 2'd2
    } bbt_phase_e;
endpackage

// File: rtl/bbt_spare_pick.sv
module bbt_spare_pick #(
    parameter int NUM_SPARE = 4,
    localparam int SW = (NUM_SPARE > 1) ? $clog2(NUM_SPARE) : 1
) (
    input  logic [NUM_SPARE-1:0] spare_bad,
    input  logic [NUM_SPARE-1:0] spare_used,
    output logic                 found,
    output logic [SW-1:0]        sel,
    output logic [NUM_SPARE-1:0] grant
);
    logic [NUM_SPARE-1:0] avail;
    logic [NUM_SPARE-1:0] lower_free;

    assign avail         = ~spare_bad & ~spare_used;
    assign lower_free[0] = 1'b0;

    for (genvar g = 1; g < NUM_SPARE; g++) begin : g_chain
        assign lower_free[g] = lower_free[g-1] | avail[g-1];
    end

    assign grant = avail & ~lower_free;
    assign found = |avail;

    always_comb begin
        sel = '0;
        for (int i = 0; i < NUM_SPARE; i++) begin
            if (grant[i]) sel = SW'(i);
        end
    end

    // R6: granted spare is the lowest available one and is itself good and unused
    always_comb begin
        a_r6_grant_onehot: assert ($onehot0(grant));
        if (found) begin
            a_r6_grant_good: assert (avail[sel] && grant[sel]);
        end
    end
endmodule

// File: rtl/bbt_lookup_stage.sv
module bbt_lookup_stage #(
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic [PW-1:0] pblk_in,
    output logic          rsp_valid,
    output logic [PW-1:0] rsp_pblk
);
    typedef struct packed {
        logic          valid;
        logic [PW-1:0] pblk;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    always_comb begin
        rsp_d       = rsp_q;
        rsp_d.valid = accept;
        if (accept) rsp_d.pblk = pblk_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_pblk  = rsp_q.pblk;

    // R1: a response only ever follows an accepted lookup
    a_r1_rsp_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(accept));
    a_r1_accept_gives_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> rsp_valid);
endmodule

// File: rtl/bbt_remap_table.sv
module bbt_remap_table
    import bbt_pkg::*;
#(
    parameter int NUM_LOG   = 8,
    parameter int NUM_SPARE = 4,
    localparam int NUM_PHYS = NUM_LOG + NUM_SPARE,
    localparam int LW = (NUM_LOG > 1) ? $clog2(NUM_LOG) : 1,
    localparam int PW = $clog2(NUM_PHYS),
    localparam int CW = $clog2(NUM_PHYS + 1),
    localparam int SW = (NUM_SPARE > 1) ? $clog2(NUM_SPARE) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scan_valid,
    input  logic          scan_bad,
    input  logic          lkp_valid,
    input  logic [LW-1:0] lkp_lblk,
    output logic          lkp_ready,
    output logic          rsp_valid,
    output logic [PW-1:0] rsp_pblk,
    input  logic          fail_valid,
    input  logic [LW-1:0] fail_lblk,
    output logic [CW-1:0] usable_count,
    output logic          out_of_spares
);
    typedef struct packed {
        bbt_phase_e                  phase;
        logic [PW-1:0]               idx;
        logic [NUM_PHYS-1:0]         bad;
        logic [NUM_SPARE-1:0]        used;
        logic [NUM_LOG-1:0][PW-1:0]  map;
        logic [CW-1:0]               usable;
        logic                        oos;
    } tbl_t;

    tbl_t st_d, st_q;

    logic                 sp_found;
    logic [SW-1:0]        sp_sel;
    logic [NUM_SPARE-1:0] sp_grant;
    logic [PW-1:0]        sp_pblk;
    logic [PW-1:0]        cur_pblk;
    logic [LW-1:0]        bld_lblk;
    logic                 accept;

    bbt_spare_pick #(.NUM_SPARE(NUM_SPARE)) spare_i (
        .spare_bad  (st_q.bad[NUM_PHYS-1:NUM_LOG]),
        .spare_used (st_q.used),
        .found      (sp_found),
        .sel        (sp_sel),
        .grant      (sp_grant)
    );

    assign sp_pblk  = PW'(NUM_LOG) + PW'(sp_sel);
    assign cur_pblk = st_q.map[fail_lblk];
    assign bld_lblk = LW'(st_q.idx);

    always_comb begin
        st_d      = st_q;
        lkp_ready = (st_q.phase == PH_RUN) && !fail_valid;
        case (st_q.phase)
            PH_SCAN: begin
                if (scan_valid) begin
                    st_d.bad[st_q.idx] = scan_bad;
                    if (scan_bad) st_d.usable = st_q.usable - CW'(1);
                    if (st_q.idx == PW'(NUM_PHYS - 1)) begin
                        st_d.phase = PH_BUILD;
                        st_d.idx   = '0;
                    end else begin
                        st_d.idx = st_q.idx + PW'(1);
                    end
                end
            end
            PH_BUILD: begin
                st_d.map[bld_lblk] = st_q.idx;
                if (st_q.bad[st_q.idx]) begin
                    if (sp_found) begin
                        st_d.map[bld_lblk] = sp_pblk;
                        st_d.used          = st_q.used | sp_grant;
                    end else begin
                        st_d.oos = 1'b1;
                    end
                end
                if (st_q.idx == PW'(NUM_LOG - 1)) begin
                    st_d.phase = PH_RUN;
                end else begin
                    st_d.idx = st_q.idx + PW'(1);
                end
            end
            PH_RUN: begin
                if (fail_valid) begin
                    if (!st_q.bad[cur_pblk]) begin
                        st_d.bad[cur_pblk] = 1'b1;
                        st_d.usable        = st_q.usable - CW'(1);
                    end
                    if (sp_found) begin
                        st_d.map[fail_lblk] = sp_pblk;
                        st_d.used           = st_q.used | sp_grant;
                    end else begin
                        st_d.oos = 1'b1;
                    end
                end
            end
            default: st_d.phase = PH_SCAN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase  <= PH_SCAN;
            st_q.idx    <= '0;
            st_q.bad    <= '0;
            st_q.used   <= '0;
            st_q.map    <= '0;
            st_q.usable <= CW'(NUM_PHYS);
            st_q.oos    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign accept = lkp_valid && lkp_ready;

    bbt_lookup_stage #(.PW(PW)) lookup_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .pblk_in   (st_q.map[lkp_lblk]),
        .rsp_valid (rsp_valid),
        .rsp_pblk  (rsp_pblk)
    );

    assign usable_count  = st_q.usable;
    assign out_of_spares = st_q.oos;

    // R7: usable count never rises
    a_r7_count_never_rises: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (usable_count <= $past(usable_count)));
    // R8: spare exhaustion error is sticky
    a_r8_oos_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        out_of_spares |=> out_of_spares);
    // R9: a lookup alongside a failure report yields no response
    a_r9_fail_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_valid && lkp_valid) |=> !rsp_valid);
    // R3: no response while scan or build is in progress
    a_r3_no_rsp_before_init: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase != PH_RUN) |=> !rsp_valid);
    // R10: failure reports before ready leave the count alone
    a_r10_early_fail_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase != PH_RUN && !scan_valid) |=> $stable(usable_count));
    // R4: a response never names a block that is currently bad (while spares remain)
    a_r4_rsp_good: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !out_of_spares) |-> !st_q.bad[rsp_pblk]);
endmodule

// File: tb/bbt_remap_table_tb.sv
module bbt_remap_table_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LW = 3;
    localparam int PW = 4;
    localparam int CW = 4;
    localparam int NVEC = 6;
    // {logical block, expected physical block} after scan with blocks 2 and 9 bad
    localparam int VEC [NVEC][2] = '{'{0, 0}, '{1, 1}, '{2, 8}, '{3, 3}, '{7, 7}, '{4, 4}};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scan_valid = 1'b0, scan_bad = 1'b0;
    logic          lkp_valid = 1'b0;
    logic [LW-1:0] lkp_lblk = '0;
    logic          lkp_ready, rsp_valid;
    logic [PW-1:0] rsp_pblk;
    logic          fail_valid = 1'b0;
    logic [LW-1:0] fail_lblk = '0;
    logic [CW-1:0] usable_count;
    logic          out_of_spares;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bbt_remap_table dut_i (
        .clk(clk), .rst_n(rst_n), .scan_valid(scan_valid), .scan_bad(scan_bad),
        .lkp_valid(lkp_valid), .lkp_lblk(lkp_lblk), .lkp_ready(lkp_ready),
        .rsp_valid(rsp_valid), .rsp_pblk(rsp_pblk), .fail_valid(fail_valid),
        .fail_lblk(fail_lblk), .usable_count(usable_count), .out_of_spares(out_of_spares)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_lookup(input int l, input int exp, input string tag);
        @(negedge clk);
        lkp_valid = 1'b1;
        lkp_lblk  = LW'(l);
        chk({tag, " ready"}, int'(lkp_ready), 1);
        @(negedge clk);
        lkp_valid = 1'b0;
        chk({tag, " rsp_valid"}, int'(rsp_valid), 1);
        chk({tag, " rsp_pblk"}, int'(rsp_pblk), exp);
    endtask

    task automatic do_fail(input int l);
        @(negedge clk);
        fail_valid = 1'b1;
        fail_lblk  = LW'(l);
        @(negedge clk);
        fail_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R3 reset ready", int'(lkp_ready), 0);
        chk("R1 reset rsp_valid", int'(rsp_valid), 0);
        chk("R7 reset usable", int'(usable_count), 12);
        chk("R8 reset oos", int'(out_of_spares), 0);
        rst_n = 1'b1;

        // R2 scan: physical 2 (data) and 9 (spare) bad
        for (int p = 0; p < 12; p++) begin
            @(negedge clk);
            scan_valid = 1'b1;
            scan_bad   = (p == 2 || p == 9);
            fail_valid = (p == 5);   // R10: early failure on logical 0
            fail_lblk  = '0;
            lkp_valid  = (p == 5);   // R3: early lookup
            lkp_lblk   = '0;
            if (p == 5) chk("R3 ready low in scan", int'(lkp_ready), 0);
            if (p == 6) chk("R3 no rsp in scan", int'(rsp_valid), 0);
        end
        @(negedge clk);
        scan_valid = 1'b0; scan_bad = 1'b0; fail_valid = 1'b0; lkp_valid = 1'b0;
        chk("R3 ready low in build", int'(lkp_ready), 0);
        while (!lkp_ready) @(negedge clk);
        chk("R2 R10 usable after scan", int'(usable_count), 10);
        chk("R4 oos after build", int'(out_of_spares), 0);

        // R1 R4 vector walk
        for (int v = 0; v < NVEC; v++) begin
            do_lookup(VEC[v][0], VEC[v][1], $sformatf("R1 R4 vec%0d", v));
        end

        // R5 R6: logical 3 fails, spare 8 used and 9 bad, so 10
        do_fail(3);
        chk("R7 usable after fail l3", int'(usable_count), 9);
        do_lookup(3, 10, "R5 R6 l3 remap");
        // R5 R6: logical 2 lives on spare 8, which fails, so 11
        do_fail(2);
        chk("R7 usable after fail l2", int'(usable_count), 8);
        do_lookup(2, 11, "R5 R6 l2 remap from spare");
        // R8: no spare left for logical 5
        do_fail(5);
        chk("R8 oos raised", int'(out_of_spares), 1);
        chk("R8 block still retired", int'(usable_count), 7);
        do_lookup(5, 5, "R8 l5 mapping kept");
        // R7: same bad block reported again
        do_fail(5);
        chk("R7 no double count", int'(usable_count), 7);

        // R9: failure and lookup in the same cycle
        @(negedge clk);
        fail_valid = 1'b1; fail_lblk = '0;
        lkp_valid  = 1'b1; lkp_lblk  = 3'd1;
        #1 chk("R9 ready low with fail", int'(lkp_ready), 0);
        @(negedge clk);
        fail_valid = 1'b0; lkp_valid = 1'b0;
        chk("R9 no rsp", int'(rsp_valid), 0);
        chk("R8 oos sticky", int'(out_of_spares), 1);
        chk("R7 usable after fail l0", int'(usable_count), 6);
        do_lookup(0, 0, "R8 l0 kept");
        do_lookup(2, 11, "R1 l2 still 11");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule